// File: doc/BRIEF.md
# Port LUT Fabric

This block is a small reconfigurable logic layer placed between the eight pin-side terminals and the eight peripheral-side terminals of one I/O port. It holds eight 3-input lookup tables. Each table picks its three inputs through its own selects and looks up the result in an 8-bit truth table. It works either combinationally or through a flip-flop. The result of table N can replace the signal going to pin N, the signal going to peripheral terminal N, or both. Where no table drives a terminal, the signal passes straight across the port.

Each input terminal can be routed through a two-flop synchronizer to the fabric clock before it reaches the tables. A single-beat write port loads the table settings, the output enables and the synchronizer enables. When the fabric enable is low, the whole port becomes a plain pass-through and every flop inside holds its value.

Top module: `port_lut_fabric`

## Requirements
- R1: After reset all table flops, synchronizer flops and configuration fields are 0, so with the fabric enabled and nothing configured, `pin_out` equals `per_in` and `per_out` equals `pin_in`.
- R2: While `fab_en` is low, `pin_out` equals `per_in` and `per_out` equals `pin_in` on every bit, whatever the configuration.
- R3: While `fab_en` is low, table flops and synchronizer flops keep their values, and evaluation resumes from those values once `fab_en` returns high.
- R4: A table's result is bit {in2,in1,in0} of its truth table, so truth value 8'h01 fanned from one source gives the inverse of that source.
- R5: A 4-bit input select of table i means: 0..3 is pin-side terminal b+s, 4..7 is peripheral-side terminal b+s-4, 8..15 is table s-8. Here b is 0 for tables 0..3 and 4 for tables 4..7.
- R6: Table i reading table j < i sees j's current output. Reading table j >= i, including itself, gives the value j captured at the last enabled clock edge.
- R7: In gated mode (mode bit 1) a table's output is its flop, which loads the table's lookup result on each enabled rising clock edge. In combinational mode (mode bit 0) the output is the lookup result, and the flop still loads it every enabled edge.
- R8: With `fab_en` high, `pin_out[n]` is table n's output when pin enable bit n is set, and `per_in[n]` otherwise. `per_out[n]` is table n's output when peripheral enable bit n is set, and `pin_in[n]` otherwise.
- R9: With a terminal's synchronizer enable set, the tables see that terminal's value from two enabled clock edges earlier. With it clear, the tables see the live value.
- R10: A write with `cfg_we` high takes effect from the next clock edge. Addresses 0..7 load table settings from bits [3:0] sel0, [7:4] sel1, [11:8] sel2, [19:12] truth table and [20] mode. Address 8 loads pin output enables [7:0], peripheral output enables [15:8], pin synchronizer enables [23:16] and peripheral synchronizer enables [31:24].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fab_en | input | 1 | Fabric enable; low gives pass-through and holds state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_in | input | 8 | Values arriving from the pins |
| per_in | input | 8 | Values arriving from the peripherals |
| pin_out | output | 8 | Values driven toward the pins |
| per_out | output | 8 | Values driven toward the peripherals |

## Verification
The two-edge synchronizer property assumes `rst_n` was already high at the earlier edge. It also assumes the inputs only change away from the rising edge, so each flop stage samples a settled value. The bench drives every input just after a rising edge and compares in the middle of the low phase. The bench never sets up a combinational loop in a form that would oscillate. Self-reference is legal because a table reading itself always gets its registered value. Configuration writes are applied as single-cycle strobes while data keeps flowing, because the checks assume settings change only at a clock edge.

// File: rtl/port_lut_fabric_pkg.sv
package port_lut_fabric_pkg;
  localparam int N_TERM = 8;
  localparam int HALF_W = N_TERM / 2;
  localparam int SEL_W  = $clog2(2 * HALF_W + N_TERM);
  localparam int TT_W   = 8;

  typedef struct packed {
    logic              gated;
    logic [TT_W-1:0]   tt;
    logic [SEL_W-1:0]  sel2;
    logic [SEL_W-1:0]  sel1;
    logic [SEL_W-1:0]  sel0;
  } lut_cfg_t;

  localparam int LUT_CFG_W = $bits(lut_cfg_t);
endpackage

// File: rtl/port_lut_fabric_cfg.sv
module port_lut_fabric_cfg
  import port_lut_fabric_pkg::*;
#(
  parameter int NT = N_TERM,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output lut_cfg_t [NT-1:0]    tbl,
  output logic [NT-1:0]        pin_oe,
  output logic [NT-1:0]        per_oe,
  output logic [NT-1:0]        pin_sen,
  output logic [NT-1:0]        per_sen
);
  for (genvar i = 0; i < NT; i++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         tbl[i] <= '0;
      else if (we && addr == AW'(i))      tbl[i] <= lut_cfg_t'(wdata[LUT_CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_oe  <= '0;
      per_oe  <= '0;
      pin_sen <= '0;
      per_sen <= '0;
    end else if (we && addr == AW'(NT)) begin
      pin_oe  <= wdata[0*NT +: NT];
      per_oe  <= wdata[1*NT +: NT];
      pin_sen <= wdata[2*NT +: NT];
      per_sen <= wdata[3*NT +: NT];
    end
  end
endmodule

// File: rtl/port_lut_fabric_sync.sv
module port_lut_fabric_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d,
  input  logic [W-1:0] sen,
  output logic [W-1:0] q_eff,
  output logic [W-1:0] s2
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else if (adv) begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q_eff = (sen & s2) | (~sen & d);
endmodule

// File: rtl/port_lut_fabric_eval.sv
module port_lut_fabric_eval
  import port_lut_fabric_pkg::*;
#(
  parameter int NT = N_TERM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  lut_cfg_t [NT-1:0] tbl,
  input  logic [NT-1:0]     pin_src,
  input  logic [NT-1:0]     per_src,
  output logic [NT-1:0]     lut_val,
  output logic [NT-1:0]     lut_q
);
  localparam int HALF = NT / 2;
  localparam int SRCN = 2 * HALF + NT;

  logic [NT-1:0] nxt;

  // Ordered evaluation: lower-index tables feed forward combinationally,
  // equal or higher index tables are read from their flops, so no loop exists.
  always_comb begin
    lut_val = '0;
    nxt     = '0;
    for (int i = 0; i < NT; i++) begin
      logic [NT-1:0]   low_m;
      logic [NT-1:0]   fb;
      logic [SRCN-1:0] sv;
      logic [2:0]      idx;
      low_m  = (NT'(1) << i) - NT'(1);
      fb     = (lut_val & low_m) | (lut_q & ~low_m);
      sv     = {fb, per_src[(i/HALF)*HALF +: HALF], pin_src[(i/HALF)*HALF +: HALF]};
      idx    = {sv[tbl[i].sel2], sv[tbl[i].sel1], sv[tbl[i].sel0]};
      nxt[i] = tbl[i].tt[idx];
      lut_val[i] = tbl[i].gated ? lut_q[i] : nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lut_q <= '0;
    else if (en) lut_q <= nxt;
  end
endmodule

// File: rtl/port_lut_fabric.sv
module port_lut_fabric
  import port_lut_fabric_pkg::*;
#(
  parameter int NT = N_TERM,
  parameter int AW = $clog2(NT + 1),
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fab_en,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [NT-1:0] pin_in,
  input  logic [NT-1:0] per_in,
  output logic [NT-1:0] pin_out,
  output logic [NT-1:0] per_out
);
  lut_cfg_t [NT-1:0] tbl;
  logic [NT-1:0] pin_oe, per_oe, pin_sen, per_sen;
  logic [NT-1:0] pin_src, per_src, pin_s2, per_s2;
  logic [NT-1:0] lut_val, lut_q, gated_mask;

  port_lut_fabric_cfg #(.NT(NT), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tbl(tbl), .pin_oe(pin_oe), .per_oe(per_oe), .pin_sen(pin_sen), .per_sen(per_sen)
  );

  port_lut_fabric_sync #(.W(NT)) u_sync_pin (
    .clk(clk), .rst_n(rst_n), .adv(fab_en), .d(pin_in), .sen(pin_sen),
    .q_eff(pin_src), .s2(pin_s2)
  );

  port_lut_fabric_sync #(.W(NT)) u_sync_per (
    .clk(clk), .rst_n(rst_n), .adv(fab_en), .d(per_in), .sen(per_sen),
    .q_eff(per_src), .s2(per_s2)
  );

  port_lut_fabric_eval #(.NT(NT)) u_eval (
    .clk(clk), .rst_n(rst_n), .en(fab_en), .tbl(tbl),
    .pin_src(pin_src), .per_src(per_src), .lut_val(lut_val), .lut_q(lut_q)
  );

  for (genvar i = 0; i < NT; i++) begin : g_mode
    assign gated_mask[i] = tbl[i].gated;
  end

  always_comb begin
    if (fab_en) begin
      pin_out = (pin_oe & lut_val) | (~pin_oe & per_in);
      per_out = (per_oe & lut_val) | (~per_oe & pin_in);
    end else begin
      pin_out = per_in;
      per_out = pin_in;
    end
  end
endmodule

// File: rtl/port_lut_fabric_chk.sv
module port_lut_fabric_chk #(
  parameter int NT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fab_en,
  input logic [NT-1:0] pin_in,
  input logic [NT-1:0] per_in,
  input logic [NT-1:0] pin_out,
  input logic [NT-1:0] per_out,
  input logic [NT-1:0] lut_q,
  input logic [NT-1:0] pin_s2,
  input logic [NT-1:0] per_s2,
  input logic [NT-1:0] gated_mask,
  input logic [NT-1:0] pin_oe,
  input logic [NT-1:0] per_oe
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lut_q == '0 && pin_s2 == '0 && per_s2 == '0)); // R1

  AST_OFF_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !fab_en |-> (pin_out == per_in && per_out == pin_in)); // R2

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fab_en |=> ($stable(lut_q) && $stable(pin_s2) && $stable(per_s2))); // R3

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_en && $past(fab_en) && $past(rst_n)) |=>
      (pin_s2 == $past(pin_in, 2) && per_s2 == $past(per_in, 2))); // R9

  for (genvar i = 0; i < NT; i++) begin : g_bit
    AST_GATED_FROM_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
      (fab_en && gated_mask[i] && pin_oe[i]) |-> pin_out[i] == lut_q[i]); // R7

    AST_PIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (fab_en && !pin_oe[i]) |-> pin_out[i] == per_in[i]); // R8

    AST_PER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (fab_en && !per_oe[i]) |-> per_out[i] == pin_in[i]); // R8
  end
endmodule

bind port_lut_fabric port_lut_fabric_chk #(.NT(NT)) u_chk (.*);

// File: tb/port_lut_fabric_tb.sv
module port_lut_fabric_tb;
  localparam int NT = 8;
  localparam int WD_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fab_en = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [NT-1:0] pin_in = '0;
  logic [NT-1:0] per_in = '0;
  logic [NT-1:0] pin_out, per_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  int       m_sel [NT][3];
  bit [7:0] m_tt [NT];
  bit       m_gated [NT];
  bit [7:0] m_poe, m_qoe, m_psen, m_qsen;
  bit [7:0] m_q, m_ps1, m_ps2, m_qs1, m_qs2;

  always #10 clk = ~clk;

  port_lut_fabric u_dut (
    .clk(clk), .rst_n(rst_n), .fab_en(fab_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pin_in(pin_in), .per_in(per_in),
    .pin_out(pin_out), .per_out(per_out)
  );

  function automatic bit [31:0] lut_word(int s0, int s1, int s2, bit [7:0] tt, bit g);
    return {11'd0, g, tt, 4'(s2), 4'(s1), 4'(s0)};
  endfunction

  task automatic model_eval(output bit [7:0] v, output bit [7:0] raw);
    bit [7:0] pe, qe;
    v = '0; raw = '0;
    for (int n = 0; n < NT; n++) begin
      pe[n] = m_psen[n] ? m_ps2[n] : pin_in[n];
      qe[n] = m_qsen[n] ? m_qs2[n] : per_in[n];
    end
    for (int i = 0; i < NT; i++) begin
      int base;
      int idx;
      base = (i / 4) * 4;
      idx = 0;
      for (int k = 0; k < 3; k++) begin
        int s;
        bit b;
        s = m_sel[i][k];
        if (s < 4)      b = pe[base + s];
        else if (s < 8) b = qe[base + s - 4];
        else if (s - 8 < i) b = v[s - 8];
        else            b = m_q[s - 8];
        if (b) idx += (1 << k);
      end
      raw[i] = m_tt[i][idx];
      v[i] = m_gated[i] ? m_q[i] : raw[i];
    end
  endtask

  task automatic tick(string tag);
    bit [7:0] v, raw, ep, eq;
    @(negedge clk);
    model_eval(v, raw);
    if (fab_en) begin
      ep = (m_poe & v) | (~m_poe & per_in);
      eq = (m_qoe & v) | (~m_qoe & pin_in);
    end else begin
      ep = per_in;
      eq = pin_in;
    end
    checks++;
    if (pin_out !== ep || per_out !== eq) begin
      fails++;
      $display("FAIL %s: pin_out=%h per_out=%h expected pin_out=%h per_out=%h",
               tag, pin_out, per_out, ep, eq);
    end
    @(posedge clk);
    if (rst_n && fab_en) begin
      m_q = raw;
      m_ps2 = m_ps1; m_ps1 = pin_in;
      m_qs2 = m_qs1; m_qs1 = per_in;
    end
    if (rst_n && cfg_we) begin
      if (cfg_addr < 4'(NT)) begin
        m_sel[cfg_addr][0] = int'(cfg_wdata[3:0]);
        m_sel[cfg_addr][1] = int'(cfg_wdata[7:4]);
        m_sel[cfg_addr][2] = int'(cfg_wdata[11:8]);
        m_tt[cfg_addr]     = cfg_wdata[19:12];
        m_gated[cfg_addr]  = cfg_wdata[20];
      end else if (cfg_addr == 4'(NT)) begin
        m_poe  = cfg_wdata[7:0];
        m_qoe  = cfg_wdata[15:8];
        m_psen = cfg_wdata[23:16];
        m_qsen = cfg_wdata[31:24];
      end
    end
    #2;
  endtask

  task automatic run(int n, string tag);
    for (int c = 0; c < n; c++) begin
      pin_in = 8'($urandom);
      per_in = 8'($urandom);
      tick(tag);
    end
  endtask

  task automatic cfg_write(int a, bit [31:0] d, string tag);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    pin_in = 8'($urandom); per_in = 8'($urandom);
    tick(tag);
    cfg_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin
      m_sel[i][0] = 0; m_sel[i][1] = 0; m_sel[i][2] = 0;
      m_tt[i] = '0; m_gated[i] = 1'b0;
    end
    m_poe = '0; m_qoe = '0; m_psen = '0; m_qsen = '0;
    m_q = '0; m_ps1 = '0; m_ps2 = '0; m_qs1 = '0; m_qs2 = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    fab_en = 1'b1;

    run(8, "R1 reset state pass-through");
    // R4 + R10: table 0 inverts peripheral terminal 0 onto pin 0
    cfg_write(0, lut_word(4, 4, 4, 8'h01, 1'b0), "R10 table write");
    cfg_write(8, 32'h0000_0001, "R10 enable write");
    run(12, "R4 inverter");
    // R5: table 5 parity of pin5, per6, pin6
    cfg_write(5, lut_word(1, 6, 2, 8'h96, 1'b0), "R5 select write");
    cfg_write(8, 32'h0000_2121, "R5 enable write");
    run(16, "R5 half routing");
    // R6: table3 toggles on itself, table2 reads table3 flop, table1 reads table0 live
    cfg_write(3, lut_word(11, 11, 11, 8'h01, 1'b0), "R6 write t3");
    cfg_write(2, lut_word(11, 11, 11, 8'h80, 1'b0), "R6 write t2");
    cfg_write(1, lut_word(8, 8, 8, 8'h80, 1'b0), "R6 write t1");
    cfg_write(8, 32'h0000_0E2F, "R6 enable write");
    run(16, "R6 table feedback");
    // R7: table 4 gated copy of pin4
    cfg_write(4, lut_word(0, 0, 0, 8'h80, 1'b1), "R7 write t4");
    cfg_write(8, 32'h0000_1F3F, "R7 enable write");
    run(16, "R7 gated output");
    // R9: synchronizers on pin0/per0/pin5 feeding tables 0 and 5
    cfg_write(8, 32'h0121_1F3F, "R9 sync write");
    run(20, "R9 synchronizer");
    // R2/R3: disable, then resume from held state
    fab_en = 1'b0;
    run(10, "R2 disabled bypass");
    cfg_write(8, 32'h0121_FFFF, "R2 write while off");
    run(4, "R2 disabled bypass");
    fab_en = 1'b1;
    run(12, "R3 resume held state");
    // R8: mixed output enables
    cfg_write(8, 32'h0000_A55A, "R8 enable write");
    run(12, "R8 output enables");
    cfg_write(8, 32'h0000_00FF, "R8 enable write");
    run(8, "R8 pin only");
    cfg_write(8, 32'h0000_FF00, "R8 enable write");
    run(8, "R8 peripheral only");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * WD_CYCLES);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run incomplete, expected finish before %0d cycles", WD_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule